// File: doc/BRIEF.md
# Valid-Gated ADC Sample Averager

This block runs one measurement of an analog-to-digital converter that sits behind a simple register port. A start pulse begins the measurement. The block first writes a tuning word to the converter's control register. It then reads the converter's output register over and over. Only words whose valid flag is set count as samples.

A short warm-up of valid samples is thrown away. After that, a fixed number of valid samples is summed. The sum is scaled by 1000 and divided by the nominal sample count, which gives a fixed-point average.

Each phase has its own limit on read attempts. If a phase reaches that limit, it stops early and a sticky overflow flag is raised. The register port uses a request that stays high until the responder returns a one-cycle acknowledge. The timing of the physical bus behind that port is not part of this block.

Top module: `adc_avg_seq`

## Requirements
- R1: An accepted start first raises `wr_req_o` with `addr_o` = 0x0009 and `wdata_o` = the `tune_val_i` value sampled on the start cycle. This request is held unchanged until `ack_i`, and no read is requested before that acknowledge.
- R2: After the write, every read request uses `addr_o` = 0x000A and stays high and stable until `ack_i`. Each acknowledged read counts as one attempt, whether or not its word is valid.
- R3: A read word is a sample only when bit 10 is set. The sample value is bits 9:0. Bits 15:11 and every word with bit 10 clear add nothing to the sum.
- R4: The first 2 valid samples of a measurement are discarded and do not enter the sum.
- R5: The next 80 valid samples are summed. 80 samples of 1023 give 81840 with no wrap.
- R6: `result_o` = floor(sum × 1000 / 80). It appears together with `done_o` two cycles after the acknowledge that completes the last read. Both are held until the next accepted start, which clears `done_o`.
- R7: Each phase (warm-up, then accumulation) allows at most 200 attempts, and the attempt count restarts at each phase. If the 200th attempt of a phase ends without reaching that phase's valid count, the phase ends and `ovf_o` is set. `ovf_o` stays set until the next accepted start. A warm-up overflow still moves on to accumulation. If the count is reached exactly on the 200th attempt, `ovf_o` is not set.
- R8: When accumulation ends early, the result still divides by 80 and `done_o` is raised while `ovf_o` is high.
- R9: `start_i` is ignored while a measurement is running. `ack_i` is ignored when no request is outstanding.
- R10: After reset, no request is raised, `addr_o`, `wdata_o` and `result_o` are 0, and `done_o` and `ovf_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a measurement (taken when idle or done) |
| tune_val_i | input | 16 | Tuning word to program before sampling |
| ack_i | input | 1 | One-cycle completion of the outstanding request |
| rd_data_i | input | 16 | Read word, sampled with `ack_i` |
| wr_req_o | output | 1 | Register write request |
| rd_req_o | output | 1 | Register read request |
| addr_o | output | 16 | Register address of the request |
| wdata_o | output | 16 | Write data |
| result_o | output | 27 | Average × 1000 |
| done_o | output | 1 | Measurement finished |
| ovf_o | output | 1 | A phase hit its attempt cap |

## Verification
The hardest cases to reach are the attempt caps. The bench must supply exactly 200 acknowledged reads in one phase before the valid count is reached, and it must also cover the case where the count is reached on exactly the 200th attempt. The read responder takes its words from a queue that each scenario fills in advance. Runs of invalid words are placed so the cap falls in warm-up, in accumulation, or exactly on the completing sample. A behavioural model follows every acknowledge and is compared on every cycle.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WARM,
    ST_ACC,
    ST_FIN,
    ST_DONE
  } avg_st_e;
endpackage

// File: rtl/adc_avg_fsm.sv
module adc_avg_fsm
  import adc_avg_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 7,
  parameter int WARM_N  = 2,
  parameter int ACC_N   = 80,
  parameter int MAX_TRY = 200,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 'h0009,
  parameter logic [ADDR_W-1:0] ADC_ADDR = 'h000A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tune_val_i,
  input  logic              ack_i,
  input  logic              valid_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              wr_req_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              clr_o,
  output logic              take_o,
  output logic              add_o,
  output logic              load_o,
  output logic              done_o,
  output logic              ovf_o
);
  localparam int TRY_W = $clog2(MAX_TRY + 1);

  avg_st_e           st_q;
  logic [TRY_W-1:0]  try_q;
  logic [DATA_W-1:0] tune_q;
  logic              ovf_q, done_q;
  logic              in_phase, hit, cap, step, idle;
  int                target;

  assign idle     = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign in_phase = (st_q == ST_WARM) || (st_q == ST_ACC);
  assign target   = (st_q == ST_WARM) ? WARM_N : ACC_N;
  assign hit      = valid_i && ((int'(cnt_i) + 1) == target);
  assign cap      = (int'(try_q) + 1) == MAX_TRY;
  assign step     = ack_i && in_phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      try_q  <= '0;
      tune_q <= '0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          st_q   <= ST_WR;
          tune_q <= tune_val_i;
          ovf_q  <= 1'b0;
          done_q <= 1'b0;
        end
        ST_WR: if (ack_i) begin
          st_q  <= ST_WARM;
          try_q <= '0;
        end
        ST_WARM, ST_ACC: if (ack_i) begin
          if (hit || cap) begin
            st_q  <= (st_q == ST_WARM) ? ST_ACC : ST_FIN;
            try_q <= '0;
            if (!hit) ovf_q <= 1'b1;
          end else begin
            try_q <= try_q + 1'b1;
          end
        end
        ST_FIN: begin
          st_q   <= ST_DONE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_req_o = (st_q == ST_WR);
  assign rd_req_o = in_phase;
  assign addr_o   = wr_req_o ? CFG_ADDR : (rd_req_o ? ADC_ADDR : '0);
  assign wdata_o  = wr_req_o ? tune_q : '0;
  // clear counters entering each phase; leaving accumulation keeps the sum
  assign clr_o    = ack_i && (wr_req_o || ((st_q == ST_WARM) && (hit || cap)));
  assign take_o   = step && valid_i;
  assign add_o    = (st_q == ST_ACC);
  assign load_o   = (st_q == ST_FIN);
  assign done_o   = done_q;
  assign ovf_o    = ovf_q;

  // R1
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !ack_i) |=> (wr_req_o && $stable(wdata_o) && !rd_req_o));
  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !ack_i) |=> (rd_req_o && $stable(addr_o)));
  // R7
  cap_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cap && !hit) |=> ovf_o);
  // R6
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_req_o && !wr_req_o));
  // R9
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_req_o, rd_req_o}));
  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && in_phase) |=> !wr_req_o);
endmodule

// File: rtl/adc_avg_acc.sv
module adc_avg_acc #(
  parameter int SAMP_W = 10,
  parameter int CNT_W  = 7,
  parameter int SUM_W  = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic              add_i,
  input  logic [SAMP_W-1:0] sample_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [SUM_W-1:0]  sum_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (take_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (add_i) sum_q <= sum_q + SUM_W'(sample_i);
    end
  end

  assign cnt_o = cnt_q;
  assign sum_o = sum_q;

  // R3
  no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !clr_i) |=> ($stable(sum_q) && $stable(cnt_q)));
  // R5
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && add_i && !clr_i) |=> (sum_q >= $past(sum_q)));
  // R4
  warm_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !add_i && !clr_i) |=> $stable(sum_q));
endmodule

// File: rtl/adc_avg_scale.sv
module adc_avg_scale #(
  parameter int SUM_W = 17,
  parameter int RES_W = 27,
  parameter int SCALE = 1000,
  parameter int DIV   = 80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic [RES_W-1:0] result_o
);
  logic [RES_W-1:0] prod, res_q;

  assign prod = RES_W'(sum_i) * RES_W'(SCALE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (load_i) res_q <= prod / RES_W'(DIV);
  end

  assign result_o = res_q;

  // R6
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(res_q));
endmodule

// File: rtl/adc_avg_seq.sv
module adc_avg_seq #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int SAMP_W    = 10,
  parameter int VALID_BIT = 10,
  parameter int WARM_N    = 2,
  parameter int ACC_N     = 80,
  parameter int MAX_TRY   = 200,
  parameter int SCALE     = 1000,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 'h0009,
  parameter logic [ADDR_W-1:0] ADC_ADDR = 'h000A,
  localparam int CNT_W = $clog2(((WARM_N > ACC_N) ? WARM_N : ACC_N) + 1),
  localparam int SUM_W = SAMP_W + $clog2(ACC_N + 1),
  localparam int RES_W = SUM_W + $clog2(SCALE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tune_val_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [RES_W-1:0]  result_o,
  output logic              done_o,
  output logic              ovf_o
);
  logic             clr, take, add, load;
  logic [CNT_W-1:0] cnt;
  logic [SUM_W-1:0] sum;
  logic             unused_rd;

  assign unused_rd = ^rd_data_i;

  adc_avg_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WARM_N(WARM_N),
    .ACC_N(ACC_N), .MAX_TRY(MAX_TRY), .CFG_ADDR(CFG_ADDR), .ADC_ADDR(ADC_ADDR)
  ) i_fsm (
    .clk_i, .rst_ni, .start_i, .tune_val_i, .ack_i,
    .valid_i (rd_data_i[VALID_BIT]),
    .cnt_i   (cnt),
    .wr_req_o, .rd_req_o, .addr_o, .wdata_o,
    .clr_o   (clr),
    .take_o  (take),
    .add_o   (add),
    .load_o  (load),
    .done_o, .ovf_o
  );

  adc_avg_acc #(.SAMP_W(SAMP_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) i_acc (
    .clk_i, .rst_ni,
    .clr_i    (clr),
    .take_i   (take),
    .add_i    (add),
    .sample_i (rd_data_i[SAMP_W-1:0]),
    .cnt_o    (cnt),
    .sum_o    (sum)
  );

  adc_avg_scale #(.SUM_W(SUM_W), .RES_W(RES_W), .SCALE(SCALE), .DIV(ACC_N)) i_scale (
    .clk_i, .rst_ni,
    .load_i   (load),
    .sum_i    (sum),
    .result_o
  );

  // R10
  ovf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (!ovf_o && !done_o));
endmodule

// File: tb/test_adc_avg_seq.sv
module test_adc_avg_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] tune = 16'h1234;
  logic        resp_ack = 1'b0, stray_ack = 1'b0;
  logic        ack;
  logic [15:0] rd_data = '0;
  logic        wr_req, rd_req, done, ovf;
  logic [15:0] addr, wdata;
  logic [26:0] result;

  int checks = 0, fails = 0, cyc = 0, lat = 0, wait_n = 0;
  logic [15:0] q[$];

  assign ack = resp_ack | stray_ack;
  always #10 clk = ~clk;

  adc_avg_seq i_adc_avg_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tune_val_i(tune),
    .ack_i(ack), .rd_data_i(rd_data), .wr_req_o(wr_req), .rd_req_o(rd_req),
    .addr_o(addr), .wdata_o(wdata), .result_o(result), .done_o(done), .ovf_o(ovf)
  );

  task automatic chk(string tag, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle,1 write,2 warm,3 acc,4 finish,5 done
  int m_st, m_cnt, m_try, m_sum, m_res, m_tune;
  bit m_ovf, m_done;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_try = 0; m_sum = 0; m_res = 0;
      m_tune = 0; m_ovf = 0; m_done = 0;
    end else begin
      case (m_st)
        0, 5: if (start) begin m_st = 1; m_tune = tune; m_ovf = 0; m_done = 0; end
        1: if (ack) begin m_st = 2; m_cnt = 0; m_try = 0; end
        2: if (ack) begin
          m_try++;
          if (rd_data[10]) m_cnt++;
          if (rd_data[10] && m_cnt == 2) begin m_st = 3; m_cnt = 0; m_try = 0; m_sum = 0; end
          else if (m_try == 200) begin m_ovf = 1; m_st = 3; m_cnt = 0; m_try = 0; m_sum = 0; end
        end
        3: if (ack) begin
          m_try++;
          if (rd_data[10]) begin m_sum += rd_data & 16'h03FF; m_cnt++; end
          if (rd_data[10] && m_cnt == 80) m_st = 4;
          else if (m_try == 200) begin m_ovf = 1; m_st = 4; end
        end
        4: begin m_st = 5; m_res = m_sum * 1000 / 80; m_done = 1; end
        default: m_st = 0;
      endcase
    end
  end

  // compare every cycle, then respond
  always @(negedge clk) begin
    chk("R1", wr_req, m_st == 1, "wr_req");
    chk("R2", rd_req, (m_st == 2 || m_st == 3), "rd_req");
    chk("R2", addr, (m_st == 1) ? 9 : ((m_st == 2 || m_st == 3) ? 10 : 0), "addr");
    chk("R1", wdata, (m_st == 1) ? m_tune : 0, "wdata");
    chk("R6", result, m_res, "result");
    chk("R6", done, m_done, "done");
    chk("R7", ovf, m_ovf, "ovf");
    if (resp_ack) resp_ack <= 1'b0;
    else if (wr_req || rd_req) begin
      if (wait_n >= lat) begin
        resp_ack <= 1'b1;
        wait_n = 0;
        if (rd_req) rd_data <= (q.size() > 0) ? q.pop_front() : 16'h0000;
      end else wait_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run(int l);
    lat = l;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; tune = tune + 16'h1111;
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", {wr_req, rd_req, done, ovf}, 0, "flags in reset");
    chk("R10", result, 0, "result in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // S1: all valid, ramp. R4 R5 R6
    q.push_back(16'h0405); q.push_back(16'h0407);
    for (int i = 0; i < 80; i++) q.push_back(16'h0400 | 16'(i * 3));
    run(0);
    chk("R6", result, 118500, "ramp average");
    chk("R4", ovf, 0, "no ovf ramp");

    // R9: stray ack while idle has no effect
    @(negedge clk); stray_ack = 1'b1; rd_data = 16'h07FF;
    @(negedge clk); stray_ack = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", result, 118500, "result after stray ack");
    chk("R9", rd_req, 0, "no read after stray ack");

    // S2: invalid words and junk upper bits, with busy start pulse. R3 R9
    q.push_back(16'h0123); q.push_back(16'h0401); q.push_back(16'hF8FF); q.push_back(16'h0402);
    for (int i = 0; i < 80; i++) begin q.push_back(16'hFBFF); q.push_back(16'hFC00 | 16'(i)); end
    fork
      run(2);
      begin repeat (60) @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; end
    join
    chk("R3", result, 39500, "junk-bit average");
    chk("R9", done, 1, "done after busy start");

    // S3: full scale. R5
    for (int i = 0; i < 82; i++) q.push_back(16'h07FF);
    run(1);
    chk("R5", result, 1023000, "full scale");

    // S4: warm-up overflow then good accumulation. R7
    for (int i = 0; i < 200; i++) q.push_back(16'h0000);
    for (int i = 0; i < 80; i++) q.push_back(16'h040A);
    run(0);
    chk("R7", ovf, 1, "warm ovf");
    chk("R7", result, 10000, "after warm ovf");

    // S5: accumulation overflow. R8
    q.push_back(16'h0400); q.push_back(16'h0400);
    for (int i = 0; i < 5; i++) q.push_back(16'h0464);
    for (int i = 0; i < 195; i++) q.push_back(16'h03FF);
    run(0);
    chk("R8", ovf, 1, "acc ovf");
    chk("R8", done, 1, "done with ovf");
    chk("R8", result, 6250, "early average");

    // S6: counts reached on exactly the 200th attempt. R7
    for (int i = 0; i < 198; i++) q.push_back(16'h0000);
    q.push_back(16'h0400); q.push_back(16'h0400);
    for (int i = 0; i < 120; i++) q.push_back(16'h0000);
    for (int i = 0; i < 80; i++) q.push_back(16'h0401);
    run(0);
    chk("R7", ovf, 0, "boundary no ovf");
    chk("R7", result, 1000, "boundary average");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule